// File: doc/BRIEF.md
# Preferred-Path Output Port Arbiter

This block is the output side of one port of a mesh router. Exactly one input of the router is the port's preferred input, and it is wired to the output in advance. A flit on that input's bypass lane reaches the output combinationally in the cycle it arrives, with no arbitration step. All other inputs reach the output through their two-entry input FIFOs. A round-robin arbiter serves them, and the granted flit leaves through an output register one cycle later. Once a packet owns the output, through either path, it keeps the output until its tail flit has passed.

The preferred input and an adaptive-mode flag can be rewritten at run time. A write is held as pending and only takes effect in a cycle when no packet owns the output, so packets already underway are not reordered. In adaptive mode the bypass lane is switched off, and every input, the preferred one included, competes through its FIFO.

A flit is `FLIT_W` bits wide. Bit `FLIT_W-1` marks a head flit and bit `FLIT_W-2` marks a tail flit. A single-flit packet has both bits set.

Top module: `pref_out_port`

## Requirements
- R1: After reset the output is invalid, no FIFO is popped, `pref_o` equals `PREF_RST` and `adapt_o` is 0.
- R2: With the output free (no owner, output register empty) and adaptive mode off, a head flit on the preferred input's bypass lane appears on `out_flit_o` with `out_valid_o` and `byp_fwd_o` high in the same cycle.
- R3: A FIFO flit granted in cycle t (its `fifo_pop_o` bit high) appears on the output in cycle t+1.
- R4: An input whose FIFO is empty but which has a flit being written this cycle (`enq_valid_i`) can compete, and the flit offered is the one being written.
- R5: While a FIFO packet owns the output, only that input is popped until its tail is granted. The bypass lane is blocked until the cycle after that tail is on the output, and bypass flits arriving meanwhile are not forwarded.
- R6: While a bypass packet owns the output, no FIFO is popped and each bypass flit is forwarded until the tail.
- R7: The arbiter searches the eligible FIFO heads in index order, starting one past the input that won the previous packet.
- R8: With adaptive mode off, the preferred input's FIFO is never popped.
- R9: A configuration write is applied in the first cycle in which no packet owns the output. That cycle starts no new packet, and `pref_o`/`adapt_o` change in the following cycle. A write with an index of `N_IN` or more is dropped.
- R10: In adaptive mode the bypass lane forwards nothing, and the preferred input's FIFO competes like any other.
- R11: A bypass flit without the head bit that arrives while the output has no owner is not forwarded.
- R12: At most one FIFO is popped per cycle, and the output carries a single source in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_nempty_i | input | N_IN | FIFO holds at least one flit, per input |
| fifo_head_i | input | N_IN x FLIT_W | Flit at the front of each FIFO |
| enq_valid_i | input | N_IN | Flit being written into each FIFO this cycle |
| enq_flit_i | input | N_IN x FLIT_W | Flit being written, per input |
| fifo_pop_o | output | N_IN | Grant: consume the offered flit of that input |
| byp_valid_i | input | N_IN | Bypass-lane flit present, per input |
| byp_flit_i | input | N_IN x FLIT_W | Bypass-lane flit, per input |
| byp_fwd_o | output | 1 | Preferred bypass flit forwarded this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pref_i | input | IDX_W | New preferred input index |
| cfg_adapt_i | input | 1 | New adaptive-mode flag |
| out_valid_o | output | 1 | Output flit valid |
| out_flit_o | output | FLIT_W | Output flit |
| pref_o | output | IDX_W | Active preferred input |
| adapt_o | output | 1 | Active adaptive mode |

## Verification
The assertions assume well-formed inputs. A FIFO head that reaches the front while the output has no owner is a head flit, because whole packets enter each FIFO in order and are drained only under the wormhole lock. `enq_valid_i` is raised only when the FIFO has a free entry. The bench builds its FIFO contents from per-input packet streams that follow these rules. Bypass-lane flits are fully random, since the block must classify any head/tail pattern on that lane as either forwarded or dead.

// File: rtl/pref_port_pkg.sv
package pref_port_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_BYP  = 2'd1,
    OWN_FIFO = 2'd2
  } owner_e;
endpackage

// File: rtl/ppa_cand.sv
module ppa_cand #(
  parameter int unsigned FLIT_W = 10
) (
  input  logic              nempty_i,
  input  logic [FLIT_W-1:0] head_i,
  input  logic              enq_valid_i,
  input  logic [FLIT_W-1:0] enq_flit_i,
  output logic              valid_o,
  output logic [FLIT_W-1:0] flit_o
);
  // empty FIFO offers the flit being written (bypass on enqueue)
  assign valid_o = nempty_i | enq_valid_i;
  assign flit_o  = nempty_i ? head_i : enq_flit_i;
endmodule

// File: rtl/ppa_rr_arb.sv
module ppa_rr_arb #(
  parameter int unsigned N_IN  = 5,
  parameter int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_IN-1:0]  gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int k = 0; k < int'(N_IN); k++) begin
      int j;
      j = (int'(ptr_i) + k) % int'(N_IN);
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/ppa_cfg.sv
module ppa_cfg #(
  parameter int unsigned N_IN     = 5,
  parameter int unsigned PREF_RST = 0,
  parameter int unsigned IDX_W    = $clog2(N_IN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_pref_i,
  input  logic             wr_adapt_i,
  input  logic             safe_i,
  output logic [IDX_W-1:0] pref_o,
  output logic             adapt_o,
  output logic             apply_o
);
  logic             pend_q;
  logic [IDX_W-1:0] pend_pref_q;
  logic             pend_adapt_q;
  logic             wr_ok;

  assign wr_ok   = we_i && (int'(wr_pref_i) < int'(N_IN));
  assign apply_o = pend_q & safe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pref_o       <= IDX_W'(PREF_RST);
      adapt_o      <= 1'b0;
      pend_q       <= 1'b0;
      pend_pref_q  <= '0;
      pend_adapt_q <= 1'b0;
    end else begin
      if (apply_o) begin
        pref_o  <= pend_pref_q;
        adapt_o <= pend_adapt_q;
        pend_q  <= 1'b0;
      end
      if (wr_ok) begin
        pend_q       <= 1'b1;
        pend_pref_q  <= wr_pref_i;
        pend_adapt_q <= wr_adapt_i;
      end
    end
  end

  // R9: a pending write survives any busy cycle
  p_pend_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !safe_i) |=> pend_q);
endmodule

// File: rtl/pref_out_port.sv
module pref_out_port
  import pref_port_pkg::*;
#(
  parameter int unsigned N_IN     = 5,
  parameter int unsigned FLIT_W   = 10,
  parameter int unsigned PREF_RST = 0,
  localparam int unsigned IDX_W   = $clog2(N_IN)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_IN-1:0]             fifo_nempty_i,
  input  logic [N_IN-1:0][FLIT_W-1:0] fifo_head_i,
  input  logic [N_IN-1:0]             enq_valid_i,
  input  logic [N_IN-1:0][FLIT_W-1:0] enq_flit_i,
  output logic [N_IN-1:0]             fifo_pop_o,
  input  logic [N_IN-1:0]             byp_valid_i,
  input  logic [N_IN-1:0][FLIT_W-1:0] byp_flit_i,
  output logic                        byp_fwd_o,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_pref_i,
  input  logic                        cfg_adapt_i,
  output logic                        out_valid_o,
  output logic [FLIT_W-1:0]           out_flit_o,
  output logic [IDX_W-1:0]            pref_o,
  output logic                        adapt_o
);
  localparam int unsigned HEAD_B = FLIT_W - 1;
  localparam int unsigned TAIL_B = FLIT_W - 2;

  owner_e             owner_q;
  logic [IDX_W-1:0]   lock_q, ptr_q;
  logic               oq_v;
  logic [FLIT_W-1:0]  oq_f;

  logic [N_IN-1:0]              cand_v, req, arb_gnt, gnt;
  logic [N_IN-1:0][FLIT_W-1:0]  cand_f;
  logic [IDX_W-1:0]             arb_idx, gidx;
  logic [IDX_W-1:0]             pref;
  logic                         adapt, apply, safe;
  logic                         byp_v, byp_ok, gv;
  logic [FLIT_W-1:0]            byp_f, gflit;

  assign safe = (owner_q == OWN_IDLE);

  ppa_cfg #(.N_IN(N_IN), .PREF_RST(PREF_RST), .IDX_W(IDX_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wr_pref_i (cfg_pref_i),
    .wr_adapt_i(cfg_adapt_i),
    .safe_i    (safe),
    .pref_o    (pref),
    .adapt_o   (adapt),
    .apply_o   (apply)
  );

  for (genvar g = 0; g < int'(N_IN); g++) begin : g_cand
    ppa_cand #(.FLIT_W(FLIT_W)) u_cand (
      .nempty_i   (fifo_nempty_i[g]),
      .head_i     (fifo_head_i[g]),
      .enq_valid_i(enq_valid_i[g]),
      .enq_flit_i (enq_flit_i[g]),
      .valid_o    (cand_v[g]),
      .flit_o     (cand_f[g])
    );
    assign req[g] = cand_v[g] & cand_f[g][HEAD_B] & (adapt | (IDX_W'(g) != pref));
  end

  ppa_rr_arb #(.N_IN(N_IN), .IDX_W(IDX_W)) u_arb (
    .req_i (req),
    .ptr_i (ptr_q),
    .gnt_o (arb_gnt),
    .idx_o (arb_idx)
  );

  // pre-selected bypass lane
  assign byp_v  = byp_valid_i[pref];
  assign byp_f  = byp_flit_i[pref];
  assign byp_ok = !adapt && !apply && !oq_v && byp_v &&
                  ((owner_q == OWN_IDLE && byp_f[HEAD_B]) || owner_q == OWN_BYP);

  always_comb begin
    gnt  = '0;
    gidx = lock_q;
    if (owner_q == OWN_FIFO) begin
      if (cand_v[lock_q]) gnt[lock_q] = 1'b1;
    end else if (owner_q == OWN_IDLE && !apply && !byp_ok) begin
      gnt  = arb_gnt;
      gidx = arb_idx;
    end
  end

  assign gv    = |gnt;
  assign gflit = cand_f[gidx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_IDLE;
      lock_q  <= '0;
      ptr_q   <= '0;
      oq_v    <= 1'b0;
      oq_f    <= '0;
    end else begin
      oq_v <= gv;
      if (gv) oq_f <= gflit;
      if (byp_ok) begin
        owner_q <= byp_f[TAIL_B] ? OWN_IDLE : OWN_BYP;
      end else if (gv) begin
        owner_q <= gflit[TAIL_B] ? OWN_IDLE : OWN_FIFO;
        lock_q  <= gidx;
      end
      if (gv && owner_q == OWN_IDLE)
        ptr_q <= (gidx == IDX_W'(N_IN - 1)) ? '0 : gidx + 1'b1;
    end
  end

  assign fifo_pop_o  = gnt;
  assign byp_fwd_o   = byp_ok;
  assign out_valid_o = byp_ok | oq_v;
  assign out_flit_o  = byp_ok ? byp_f : oq_f;
  assign pref_o      = pref;
  assign adapt_o     = adapt;

  p_single_pop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_pop_o));
  p_fifo_to_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_pop_o) |=> (out_valid_o && !byp_fwd_o));
  p_byp_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_FIFO) |-> !byp_fwd_o);
  p_byp_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_BYP) |-> (fifo_pop_o == '0));
  p_pref_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adapt_o |-> !fifo_pop_o[pref_o]);
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != OWN_IDLE) |=> ($stable(pref_o) && $stable(adapt_o)));
endmodule

// File: tb/pref_out_port_tb_top.sv
`timescale 1ns/1ps
module pref_out_port_tb_top;
  localparam int N  = 5;
  localparam int FW = 10;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]         fifo_nempty, enq_valid, byp_valid, pop;
  logic [N-1:0][FW-1:0] fifo_head, enq_flit, byp_flit;
  logic                 byp_fwd, cfg_we, cfg_adapt, out_valid, adapt;
  logic [IW-1:0]        cfg_pref, pref;
  logic [FW-1:0]        out_flit;

  pref_out_port #(.N_IN(N), .FLIT_W(FW), .PREF_RST(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_nempty_i(fifo_nempty), .fifo_head_i(fifo_head),
    .enq_valid_i(enq_valid), .enq_flit_i(enq_flit), .fifo_pop_o(pop),
    .byp_valid_i(byp_valid), .byp_flit_i(byp_flit), .byp_fwd_o(byp_fwd),
    .cfg_we_i(cfg_we), .cfg_pref_i(cfg_pref), .cfg_adapt_i(cfg_adapt),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .pref_o(pref), .adapt_o(adapt)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // bench FIFOs and stimulus
  logic [FW-1:0] qd [N][2];
  int            qn [N];
  logic          off_v [N];
  logic [FW-1:0] off_f [N];
  logic          bv [N];
  logic [FW-1:0] bf [N];
  logic          s_we, s_adapt;
  int            s_pref;

  // reference model state
  int m_own, m_lock, m_ptr, m_pref, m_adapt, m_pend, m_ppref, m_padapt, m_oqv;
  logic [FW-1:0] m_oqf;
  int e_apply, e_bypok, e_gidx;

  function automatic logic [FW-1:0] fl(input bit h, input bit t, input int d);
    return {h, t, 8'(d)};
  endfunction

  function automatic bit cv(input int j);
    return qn[j] > 0 || off_v[j];
  endfunction
  function automatic logic [FW-1:0] cf(input int j);
    return qn[j] > 0 ? qd[j][0] : off_f[j];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++) begin off_v[i] = 0; off_f[i] = '0; bv[i] = 0; bf[i] = '0; end
    s_we = 0; s_adapt = 0; s_pref = 0;
  endtask

  task automatic push(input int i, input logic [FW-1:0] f);
    qd[i][qn[i]] = f; qn[i]++;
  endtask

  task automatic model_reset();
    m_own = 0; m_lock = 0; m_ptr = 0; m_pref = 0; m_adapt = 0;
    m_pend = 0; m_ppref = 0; m_padapt = 0; m_oqv = 0; m_oqf = '0;
    for (int i = 0; i < N; i++) qn[i] = 0;
    clear_stim();
  endtask

  task automatic tick();
    logic [FW-1:0] b, g;
    logic [N-1:0]  epop;
    logic          ev;
    logic [FW-1:0] ef;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      fifo_nempty[i] = qn[i] > 0;
      fifo_head[i]   = qn[i] > 0 ? qd[i][0] : '0;
      enq_valid[i]   = off_v[i];
      enq_flit[i]    = off_f[i];
      byp_valid[i]   = bv[i];
      byp_flit[i]    = bf[i];
    end
    cfg_we = s_we; cfg_pref = IW'(s_pref); cfg_adapt = s_adapt;
    #0.5;
    e_apply = (m_pend != 0 && m_own == 0);
    b = bf[m_pref];
    e_bypok = (m_adapt == 0 && !e_apply && m_oqv == 0 && bv[m_pref] &&
               ((m_own == 0 && b[FW-1]) || m_own == 1));
    e_gidx = -1;
    if (m_own == 2) begin
      if (cv(m_lock)) e_gidx = m_lock;
    end else if (m_own == 0 && !e_apply && !e_bypok) begin
      for (int k = 0; k < N; k++) begin
        int j;
        j = (m_ptr + k) % N;
        if (e_gidx < 0 && cv(j) && cf(j)[FW-1] && (m_adapt != 0 || j != m_pref)) e_gidx = j;
      end
    end
    epop = '0;
    if (e_gidx >= 0) epop[e_gidx] = 1'b1;
    ev = e_bypok || m_oqv != 0;
    ef = e_bypok ? b : (m_oqv != 0 ? m_oqf : out_flit);
    chk(cur_req, {out_valid, out_flit, pop, byp_fwd, pref, adapt},
                 {ev, ef, epop, 1'(e_bypok), IW'(m_pref), 1'(m_adapt)});
    @(posedge clk);
    // model update
    g = (e_gidx >= 0) ? cf(e_gidx) : '0;
    if (e_bypok) m_own = b[FW-2] ? 0 : 1;
    else if (e_gidx >= 0) begin
      if (m_own == 0) m_ptr = (e_gidx + 1) % N;
      m_own = g[FW-2] ? 0 : 2;
      m_lock = e_gidx;
    end
    m_oqv = (e_gidx >= 0);
    if (e_gidx >= 0) m_oqf = g;
    if (e_apply) begin m_pref = m_ppref; m_adapt = m_padapt; m_pend = 0; end
    if (s_we && s_pref < N) begin m_pend = 1; m_ppref = s_pref; m_padapt = s_adapt; end
    for (int i = 0; i < N; i++) begin
      bit used;
      used = 0;
      if (epop[i]) begin
        if (qn[i] > 0) begin qd[i][0] = qd[i][1]; qn[i]--; end
        else used = 1;
      end
      if (off_v[i] && !used) push(i, off_f[i]);
    end
    clear_stim();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  int rem [N];
  int seq = 0;

  task automatic main_seq();
    model_reset();
    byp_valid = '0; byp_flit = '0; enq_valid = '0; enq_flit = '0;
    fifo_nempty = '0; fifo_head = '0; cfg_we = 0; cfg_pref = '0; cfg_adapt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {out_valid, pop, pref, adapt}, '0);
    rst_n = 1'b1;
    cur_req = "R1"; run(2);

    cur_req = "R2";
    bv[0] = 1; bf[0] = fl(1, 1, 8'h11); tick();
    bv[1] = 1; bf[1] = fl(1, 1, 8'h12); tick(); // non-preferred lane ignored
    run(1);

    cur_req = "R6";
    push(2, fl(1, 1, 8'h21));
    bv[0] = 1; bf[0] = fl(1, 0, 8'h22); tick();
    bv[0] = 1; bf[0] = fl(0, 0, 8'h23); tick();
    run(1);
    bv[0] = 1; bf[0] = fl(0, 1, 8'h24); tick();
    run(3);

    cur_req = "R3";
    push(1, fl(1, 1, 8'h31)); push(1, fl(1, 1, 8'h32));
    run(4);

    cur_req = "R4";
    off_v[3] = 1; off_f[3] = fl(1, 1, 8'h41); tick();
    run(2);

    cur_req = "R5";
    push(2, fl(1, 0, 8'h51)); push(2, fl(0, 0, 8'h52));
    tick();
    bv[0] = 1; bf[0] = fl(1, 1, 8'h53); tick();
    bv[0] = 1; bf[0] = fl(1, 1, 8'h54); off_v[2] = 1; off_f[2] = fl(0, 1, 8'h55); tick();
    bv[0] = 1; bf[0] = fl(1, 1, 8'h56); tick();
    bv[0] = 1; bf[0] = fl(1, 1, 8'h57); tick();
    run(2);

    cur_req = "R7";
    for (int i = 1; i < N; i++) begin push(i, fl(1, 1, 8'h70 + i)); push(i, fl(1, 1, 8'h78 + i)); end
    run(11);

    cur_req = "R8";
    push(0, fl(1, 1, 8'h81)); push(1, fl(1, 1, 8'h82));
    run(4);

    cur_req = "R9";
    push(1, fl(1, 0, 8'h91)); push(1, fl(0, 0, 8'h92));
    s_we = 1; s_pref = 2; tick();
    run(2);
    off_v[1] = 1; off_f[1] = fl(0, 1, 8'h93); tick();
    run(4);
    s_we = 1; s_pref = 6; s_adapt = 1; tick(); // dropped
    run(3);

    cur_req = "R10";
    s_we = 1; s_pref = 2; s_adapt = 1; tick();
    run(2);
    push(2, fl(1, 1, 8'hA1));
    bv[2] = 1; bf[2] = fl(1, 1, 8'hA2); tick();
    bv[2] = 1; bf[2] = fl(1, 1, 8'hA3); tick();
    run(2);
    s_we = 1; s_pref = 0; s_adapt = 0; tick();
    run(3);

    cur_req = "R11";
    bv[0] = 1; bf[0] = fl(0, 0, 8'hB1); tick();
    bv[0] = 1; bf[0] = fl(0, 1, 8'hB2); tick();
    run(1);

    cur_req = "R12";
    for (int i = 0; i < N; i++) rem[i] = 0;
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (qn[i] < 2 && ($urandom % 3) == 0) begin
          bit h;
          h = (rem[i] == 0);
          if (h) rem[i] = 1 + int'($urandom % 3);
          rem[i]--;
          seq++;
          off_v[i] = 1; off_f[i] = fl(h, rem[i] == 0, seq);
        end
        bv[i] = ($urandom % 3) == 0;
        bf[i] = fl($urandom % 2, $urandom % 2, $urandom);
      end
      if (($urandom % 60) == 0) begin
        s_we = 1; s_pref = int'($urandom % 8); s_adapt = ($urandom % 3) == 0;
      end
      tick();
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule